// File: doc/BRIEF.md
# Balanced Ternary Add/Subtract Unit

A purely combinational arithmetic unit for signed integers held as a fixed number of balanced-ternary digits. Each digit has a value of -1, 0 or +1 and is carried as a two-bit code. The unit forms the sum of its two operands. Either operand can be negated on the way in: the first through its own control, and the second through the subtract control. Negation inverts every digit. It needs no sign bit and no two's complement correction, because the sign of a balanced-ternary number follows from its most significant nonzero digit.

A keep-count input truncates the result to its k most significant digits by clearing every lower digit. No increment or correction is applied. The carry out of the top digit is reported as an overflow flag. With the default of 8 digits, the unit covers the range -3280 to +3280.

Top module: `bt_addsub`

## Requirements
- R1: Digit code: 2'b00 is 0, 2'b01 is +1 and 2'b11 is -1. Digit i sits at bits [2i+1:2i], with digit 0 least significant. An input digit with code 2'b10 is read as 0.
- R2: No digit of `res_o` ever carries the code 2'b10.
- R3: With `sub_i`=0, `neg_a_i`=0 and `keep_i`>=N_DIG, `res_o` is the balanced-ternary value A+B whenever that value lies within ±(3^N_DIG-1)/2.
- R4: With `sub_i`=1, the unit computes A-B by adding the digit-wise inverse of B.
- R5: With `neg_a_i`=1, A is replaced by -A. Combined with `sub_i`=1, the result is -A-B.
- R6: Negation is exact digit inversion: with B=0 and `neg_a_i`=1, each digit of `res_o` is the inverse of the matching digit of A.
- R7: `ovf_o` is 1 exactly when the true result lies outside ±(3^N_DIG-1)/2. In that case `res_o` holds the true result minus 3^N_DIG (positive overflow) or plus 3^N_DIG (negative overflow).
- R8: `keep_i`=k with k<N_DIG clears the N_DIG-k least significant result digits to 0 and leaves the rest unchanged. No rounding increment is applied, and `keep_i`>=N_DIG keeps every digit.
- R9: `ovf_o` does not depend on `keep_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | 2*N_DIG | Operand A, one two-bit code per digit |
| b_i | input | 2*N_DIG | Operand B, one two-bit code per digit |
| sub_i | input | 1 | 1: subtract B (B is inverted before the add) |
| neg_a_i | input | 1 | 1: invert A before the add |
| keep_i | input | KEEP_W | Number of most significant result digits kept |
| res_o | output | 2*N_DIG | Result digits |
| ovf_o | output | 1 | Carry out of the top digit is nonzero |

## Verification
The unit holds no state, so both `res_o` and `ovf_o` are due in the same cycle as the operands and controls that produce them, with zero register stages in between. The bench changes inputs only on a falling clock edge. It then waits a quarter period for the carry chain to settle and samples both outputs before the next rising edge, so no check reads a value from a previous stimulus. Every check compares the whole result vector, because each integer has exactly one balanced-ternary form.

// File: rtl/bt_pkg.sv
package bt_pkg;
  typedef logic [1:0] trit_t;

  localparam trit_t T_ZERO = 2'b00;
  localparam trit_t T_POS  = 2'b01;
  localparam trit_t T_NEG  = 2'b11;

  // code 2'b10 decodes to zero
  function automatic int trit_val(trit_t t);
    case (t)
      T_POS:   return 1;
      T_NEG:   return -1;
      default: return 0;
    endcase
  endfunction

  function automatic trit_t trit_enc(int v);
    if (v > 0)      return T_POS;
    else if (v < 0) return T_NEG;
    else            return T_ZERO;
  endfunction
endpackage

// File: rtl/bt_neg.sv
module bt_neg
  import bt_pkg::*;
(
  input  trit_t d_i,
  input  logic  inv_i,
  output trit_t d_o
);
  always_comb begin
    case (d_i)
      T_POS:   d_o = inv_i ? T_NEG : T_POS;
      T_NEG:   d_o = inv_i ? T_POS : T_NEG;
      default: d_o = T_ZERO;
    endcase
  end

  always_comb begin
    AST_NEG_VAL: assert (trit_val(d_o) == (inv_i ? -trit_val(d_i) : trit_val(d_i)))
      else $error("negation mismatch"); // R6
    AST_NEG_CODE: assert (d_o != 2'b10) else $error("illegal code"); // R1
  end
endmodule

// File: rtl/bt_digit_add.sv
module bt_digit_add
  import bt_pkg::*;
(
  input  trit_t a_i,
  input  trit_t b_i,
  input  trit_t c_i,
  output trit_t s_o,
  output trit_t c_o
);
  logic [2:0] tot;  // two's complement total in -3..3

  always_comb begin
    tot = 3'(trit_val(a_i)) + 3'(trit_val(b_i)) + 3'(trit_val(c_i));
    case (tot)
      3'd3: begin s_o = T_ZERO; c_o = T_POS;  end
      3'd2: begin s_o = T_NEG;  c_o = T_POS;  end
      3'd1: begin s_o = T_POS;  c_o = T_ZERO; end
      3'd7: begin s_o = T_NEG;  c_o = T_ZERO; end
      3'd6: begin s_o = T_POS;  c_o = T_NEG;  end
      3'd5: begin s_o = T_ZERO; c_o = T_NEG;  end
      default: begin s_o = T_ZERO; c_o = T_ZERO; end
    endcase
  end

  always_comb begin
    AST_DIGIT_BAL: assert (trit_val(s_o) + 3 * trit_val(c_o) ==
                           trit_val(a_i) + trit_val(b_i) + trit_val(c_i))
      else $error("digit balance"); // R3
    AST_SUM_CODE: assert (s_o != 2'b10 && c_o != 2'b10) else $error("illegal code"); // R2
  end
endmodule

// File: rtl/bt_trunc.sv
module bt_trunc
  import bt_pkg::*;
#(
  parameter int unsigned N_DIG  = 8,
  parameter int unsigned KEEP_W = $clog2(N_DIG + 1)
) (
  input  logic [2*N_DIG-1:0] d_i,
  input  logic [KEEP_W-1:0]  keep_i,
  output logic [2*N_DIG-1:0] d_o
);
  for (genvar i = 0; i < N_DIG; i++) begin : g_dig
    logic keep_dig;
    assign keep_dig = (32'(i) + 32'(keep_i)) >= N_DIG;
    assign d_o[2*i+:2] = keep_dig ? d_i[2*i+:2] : T_ZERO;

    always_comb begin
      AST_TRUNC_ZERO: assert (keep_dig || d_o[2*i+:2] == T_ZERO)
        else $error("low digit not cleared"); // R8
      AST_TRUNC_KEEP: assert (!keep_dig || d_o[2*i+:2] == d_i[2*i+:2])
        else $error("kept digit altered"); // R8
    end
  end
endmodule

// File: rtl/bt_addsub.sv
module bt_addsub
  import bt_pkg::*;
#(
  parameter int unsigned N_DIG  = 8,
  parameter int unsigned KEEP_W = $clog2(N_DIG + 1)
) (
  input  logic [2*N_DIG-1:0] a_i,
  input  logic [2*N_DIG-1:0] b_i,
  input  logic               sub_i,
  input  logic               neg_a_i,
  input  logic [KEEP_W-1:0]  keep_i,
  output logic [2*N_DIG-1:0] res_o,
  output logic               ovf_o
);
  localparam int unsigned VW = 2 * N_DIG;

  logic [VW-1:0] a_eff, b_eff, sum_raw;
  trit_t         carry [N_DIG+1];

  assign carry[0] = T_ZERO;

  for (genvar i = 0; i < N_DIG; i++) begin : g_dig
    bt_neg u_neg_a (.d_i(a_i[2*i+:2]), .inv_i(neg_a_i), .d_o(a_eff[2*i+:2]));
    bt_neg u_neg_b (.d_i(b_i[2*i+:2]), .inv_i(sub_i),   .d_o(b_eff[2*i+:2]));
    bt_digit_add u_add (
      .a_i(a_eff[2*i+:2]),
      .b_i(b_eff[2*i+:2]),
      .c_i(carry[i]),
      .s_o(sum_raw[2*i+:2]),
      .c_o(carry[i+1])
    );
  end

  bt_trunc #(.N_DIG(N_DIG), .KEEP_W(KEEP_W)) u_trunc (
    .d_i(sum_raw), .keep_i(keep_i), .d_o(res_o)
  );

  assign ovf_o = (carry[N_DIG] != T_ZERO);

  always_comb begin
    for (int i = 0; i < N_DIG; i++) begin
      AST_RES_CODE: assert (res_o[2*i+:2] != 2'b10) else $error("illegal result code"); // R2
    end
    AST_NO_OVERFLOW_ZERO: assert (!ovf_o || sum_raw != '0 || carry[N_DIG] == T_ZERO)
      else $error("overflow flag"); // R7
  end
endmodule

// File: tb/bt_addsub_tb.sv
module bt_addsub_tb;
  localparam int N  = 8;
  localparam int KW = 4;
  localparam int LIM = 3280;
  localparam int MOD = 6561;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic [2*N-1:0] a, b, res;
  logic           sub, nega, ovf;
  logic [KW-1:0]  keep;

  int n_run  = 0;
  int n_fail = 0;
  int cycles = 0;

  bt_addsub #(.N_DIG(N), .KEEP_W(KW)) u_dut (
    .a_i(a), .b_i(b), .sub_i(sub), .neg_a_i(nega), .keep_i(keep),
    .res_o(res), .ovf_o(ovf)
  );

  function automatic logic [2*N-1:0] to_bt(int v);
    logic [2*N-1:0] r = '0;
    for (int i = 0; i < N; i++) begin
      int m = ((v % 3) + 3) % 3;
      if (m == 1)      begin r[2*i+:2] = 2'b01; v = (v - 1) / 3; end
      else if (m == 2) begin r[2*i+:2] = 2'b11; v = (v + 1) / 3; end
      else             v = v / 3;
    end
    return r;
  endfunction

  localparam int TV [15][5] = '{
    '{5, 7, 0, 0, 8},
    '{100, -37, 0, 0, 8},
    '{-1200, -900, 0, 0, 8},
    '{3280, 0, 0, 0, 8},
    '{1234, 1234, 1, 0, 8},
    '{50, 80, 1, 0, 8},
    '{200, 13, 0, 1, 8},
    '{-77, 300, 1, 1, 8},
    '{1000, 2000, 0, 0, 8},
    '{3000, 1000, 0, 0, 8},
    '{-3000, -1000, 0, 0, 8},
    '{1234, 567, 0, 0, 5},
    '{-2222, 100, 0, 0, 3},
    '{700, 1, 0, 0, 0},
    '{999, 1, 0, 0, 15}
  };

  task automatic check(string req, logic [2*N-1:0] exp_r, logic exp_o);
    n_run++;
    if (res !== exp_r) begin
      n_fail++;
      $display("FAIL %s res act=%b exp=%b", req, res, exp_r);
    end
    n_run++;
    if (ovf !== exp_o) begin
      n_fail++;
      $display("FAIL %s ovf act=%b exp=%b", req, ovf, exp_o);
    end
    for (int i = 0; i < N; i++) begin
      if (res[2*i+:2] == 2'b10) begin
        n_fail++;
        $display("FAIL R2 digit %0d act=10 exp=not 10", i);
      end
    end
  endtask

  task automatic apply(logic [2*N-1:0] av, logic [2*N-1:0] bv, logic s, logic na, int k);
    @(negedge clk);
    a = av; b = bv; sub = s; nega = na; keep = KW'(k);
    #5;
  endtask

  task automatic run_vec(int av, int bv, int s, int na, int k);
    int tot = (na != 0 ? -av : av) + (s != 0 ? -bv : bv);
    logic o = (tot > LIM) || (tot < -LIM);
    logic [2*N-1:0] e;
    string tag;
    if (tot > LIM)  tot -= MOD;
    if (tot < -LIM) tot += MOD;
    e = to_bt(tot);
    for (int i = 0; i < N; i++) if (i + k < N) e[2*i+:2] = 2'b00;
    if (k < N)        tag = "R8";
    else if (o)       tag = "R7";
    else if (na != 0) tag = "R5";
    else if (s != 0)  tag = "R4";
    else              tag = "R3";
    apply(to_bt(av), to_bt(bv), s[0], na[0], k);
    check(tag, e, o);
  endtask

  initial begin
    logic [2*N-1:0] p, f;
    a = '0; b = '0; sub = 0; nega = 0; keep = KW'(8);
    #5;
    check("R3", '0, 1'b0);  // idle: zero operands give zero

    for (int t = 0; t < 15; t++) run_vec(TV[t][0], TV[t][1], TV[t][2], TV[t][3], TV[t][4]);

    // R6: digit-wise inversion
    p = to_bt(1234);
    for (int i = 0; i < N; i++)
      f[2*i+:2] = (p[2*i+:2] == 2'b01) ? 2'b11 : (p[2*i+:2] == 2'b11) ? 2'b01 : 2'b00;
    apply(p, '0, 1'b0, 1'b1, 8);
    check("R6", f, 1'b0);

    // R1: illegal input code read as zero
    apply({N{2'b10}}, to_bt(42), 1'b0, 1'b0, 8);
    check("R1", to_bt(42), 1'b0);
    apply(to_bt(-5), {N{2'b10}}, 1'b1, 1'b0, 8);
    check("R1", to_bt(-5), 1'b0);

    // R9: overflow kept when all digits cleared
    apply(to_bt(3280), to_bt(3280), 1'b0, 1'b0, 0);
    check("R9", '0, 1'b1);
    apply(to_bt(-3280), to_bt(3280), 1'b1, 1'b0, 2);
    check("R9", to_bt(-6560 + MOD) & {{4{2'b11}}, {(N-4){2'b00}}} |
                 (to_bt(1) & {{2{2'b11}}, {(N-2){2'b00}}}), 1'b1);

    // R7: smallest overflow at each end
    run_vec(3280, 1, 0, 0, 8);
    run_vec(-3280, 1, 1, 0, 8);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 5000) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog act=%0d exp<=5000 cycles", cycles);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule